// File: doc/BRIEF.md
# Stereo-Duplicating Serial Sample Transmitter

This block sends one mono audio sample to a serial codec as a stereo pair. A frame-start pulse loads a 16-bit word in parallel. The block then puts that word on a single serial data line twice in a row, so the left-channel slot and the right-channel slot both carry the same sample. The word goes out most significant bit first. The first bit of the second copy comes straight after the least significant bit of the first copy.

Everything runs on the system clock. The bit clock is never used as a clock. Instead, a one-cycle strobe marks each falling edge of the bit clock, and the line moves on by exactly one bit per strobe. A frame lasts 64 strobes. After the 32 data bits the line is held low until the next frame-start pulse. The frame-start pulse is normally one strobe wide and lines up with a strobe. The output is a registered bit, so it changes only at system clock edges.

Top module: `serdac_tx`

## Requirements
- R1: A synchronous active-high reset drives the serial line low and marks the transmitter as finished. Until a word is loaded, the line stays low whatever the strobes do. A reset during a transmission also stops it.
- R2: When the load input is high at a clock edge, the word input is captured. From the next cycle the line shows bit 15 of that word.
- R3: Each strobe after a load moves the line to the next lower bit. After k strobes (1 ≤ k ≤ 15) the line shows bit 15−k of the loaded word.
- R4: The second copy follows with no gap. After k strobes (16 ≤ k ≤ 31) the line shows bit 31−k, so strobe 16 brings bit 15 back.
- R5: The 32nd strobe after a load, and every strobe after it, drives the line to 0. The line stays 0 until the next load.
- R6: In a cycle with neither load nor strobe, the line and the transmit position keep their values. A change on the word input has no effect outside a load cycle.
- R7: If load and strobe are high in the same cycle, the load wins. The next cycle shows bit 15 of the new word, and counting restarts from that bit.
- R8: A load in the middle of a transmission drops the old word and restarts the 32-bit sequence with the new word.
- R9: With a load on every 64th strobe, each frame carries 32 data bits followed by 32 zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_load_i | input | 1 | Frame-start pulse; captures sample_i |
| bit_strobe_i | input | 1 | One-cycle enable marking a bit-clock falling edge |
| sample_i | input | 16 | Parallel mono sample |
| sdata_o | output | 1 | Registered serial data line to the codec |

## Verification
The bench sweeps walking-one words and several mixed patterns. It checks each strobe position against a bit-index formula and also checks idle cycles between strobes. A design that sent the bits LSB first or shifted a zero in behind the word would break the R3/R4 positions. A design that left a gap between the two copies would show it at strobe 16. A design that forgot to mute after the pair, or let a loose strobe leave reset with data on the line, would show nonzero bits where R1/R5 expect zeros. The bench also applies load together with a strobe, reloads in mid-word, and runs back-to-back 64-strobe frames. An implementation that gave the strobe priority over the load, or kept the old position, would show the wrong bit right after the load.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    localparam int unsigned SAMPLE_W      = 16;
    localparam int unsigned COPIES        = 2;
    localparam int unsigned FRAME_STROBES = 64;

    // per-cycle action shared by all datapath stages
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2,
        ACT_MUTE  = 2'd3
    } act_e;

    // load beats strobe; a strobe after the last bit mutes the line
    function automatic act_e pick_act(input logic load, input logic strobe,
                                      input logic finished);
        if (load)
            return ACT_LOAD;
        if (strobe)
            return finished ? ACT_MUTE : ACT_SHIFT;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/serdac_count.sv
module serdac_count
    import serdac_pkg::*;
#(
    parameter int unsigned TOTAL = 32,
    localparam int unsigned CW   = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act_i,
    output logic [CW-1:0] pos_o,
    output logic          finished_o
);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= CW'(TOTAL);
        end else begin
            unique case (act_i)
                ACT_LOAD:  pos_q <= CW'(1);
                ACT_SHIFT: pos_q <= pos_q + CW'(1);
                default:   pos_q <= pos_q;
            endcase
        end
    end

    assign pos_o      = pos_q;
    assign finished_o = (pos_q == CW'(TOTAL));

    // R5
    pos_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= CW'(TOTAL));

endmodule

// File: rtl/serdac_rotor.sv
module serdac_rotor
    import serdac_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act_i,
    input  logic [W-1:0] word_i,
    output logic         head_o
);

    logic [W-1:0] ring_q;
    logic [W-1:0] ring_rot;
    logic [W-1:0] word_rot;

    // rotate left by one: bit i takes bit i-1, bit 0 takes the top bit
    for (genvar i = 0; i < W; i++) begin : g_rot
        assign ring_rot[i] = ring_q[(i + W - 1) % W];
        assign word_rot[i] = word_i[(i + W - 1) % W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= '0;
        end else begin
            unique case (act_i)
                ACT_LOAD:  ring_q <= word_rot;
                ACT_SHIFT: ring_q <= ring_rot;
                default:   ring_q <= ring_q;
            endcase
        end
    end

    assign head_o = ring_q[W-1];

endmodule

// File: rtl/serdac_drive.sv
module serdac_drive
    import serdac_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic clk,
    input  logic rst,
    input  act_e act_i,
    input  logic msb_i,
    input  logic head_i,
    output logic line_o
);

    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_LOAD:  line_q <= msb_i;
                ACT_SHIFT: line_q <= head_i;
                ACT_MUTE:  line_q <= 1'b0;
                default:   line_q <= line_q;
            endcase
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/serdac_tx.sv
module serdac_tx
    import serdac_pkg::*;
#(
    parameter int unsigned W      = SAMPLE_W,
    parameter int unsigned NCOPY  = COPIES,
    localparam int unsigned TOTAL = W * NCOPY,
    localparam int unsigned CW    = $clog2(TOTAL + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_load_i,
    input  logic         bit_strobe_i,
    input  logic [W-1:0] sample_i,
    output logic         sdata_o
);

    act_e          act;
    logic [CW-1:0] pos;
    logic          finished;
    logic          head;

    assign act = pick_act(frame_load_i, bit_strobe_i, finished);

    serdac_count #(.TOTAL(TOTAL)) u_count (
        .clk        (clk),
        .rst        (rst),
        .act_i      (act),
        .pos_o      (pos),
        .finished_o (finished)
    );

    serdac_rotor #(.W(W)) u_rotor (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .word_i (sample_i),
        .head_o (head)
    );

    serdac_drive #(.W(W)) u_drive (
        .clk    (clk),
        .rst    (rst),
        .act_i  (act),
        .msb_i  (sample_i[W-1]),
        .head_i (head),
        .line_o (sdata_o)
    );

    // R2
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
        frame_load_i |=> (sdata_o == $past(sample_i[W-1])) && (pos == CW'(1)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_load_i && !bit_strobe_i) |=> ($stable(sdata_o) && $stable(pos)));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe_i && !frame_load_i && !finished) |=> (pos == $past(pos) + CW'(1)));

    // R5
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe_i && !frame_load_i && finished) |=> !sdata_o);

endmodule

// File: tb/serdac_tx_test.sv
module serdac_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        strobe = 1'b0;
    logic [15:0] word = '0;
    logic        ser;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serdac_tx uut (
        .clk          (clk),
        .rst          (rst),
        .frame_load_i (load),
        .bit_strobe_i (strobe),
        .sample_i     (word),
        .sdata_o      (ser)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge: drive, then return at the next falling edge
    task automatic cyc(input logic l, input logic e, input logic [15:0] w);
        load = l; strobe = e; word = w;
        @(negedge clk);
        load = 1'b0; strobe = 1'b0;
    endtask

    function automatic logic expect_bit(input logic [15:0] w, input int k);
        if (k >= 32) return 1'b0;
        return w[15 - (k % 16)];
    endfunction

    function automatic string tag_for(input int k);
        if (k < 16) return "R3";
        if (k < 32) return "R4";
        return "R5";
    endfunction

    task automatic run_word(input logic [15:0] w, input int gap, input bit with_en);
        int lastv;
        cyc(1'b1, with_en, w);
        chk(ser == w[15], with_en ? "R7 load+strobe" : "R2 load msb", ser, w[15]);
        for (int k = 1; k <= 36; k++) begin
            for (int g = 0; g < gap; g++) begin
                lastv = ser;
                cyc(1'b0, 1'b0, ~w);
                chk(ser == lastv, "R6 idle hold", ser, lastv);
            end
            cyc(1'b0, 1'b1, ~w);
            chk(ser == expect_bit(w, k), tag_for(k), ser, expect_bit(w, k));
        end
    endtask

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0000;
        pats[3] = 16'h8001; pats[4] = 16'h1234; pats[5] = 16'h7FFE;

        repeat (3) @(negedge clk);
        chk(ser == 1'b0, "R1 reset state", ser, 0);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b1, 16'hFFFF);
            chk(ser == 1'b0, "R1 strobe before load", ser, 0);
        end

        for (int b = 0; b < 16; b++)
            run_word(16'(1) << b, 0, b[0]);
        for (int i = 0; i < 6; i++)
            run_word(pats[i], 2, i[0]);

        // R8: reload in mid-word
        cyc(1'b1, 1'b0, 16'hF0F0);
        for (int k = 1; k <= 10; k++) cyc(1'b0, 1'b1, 16'h0);
        cyc(1'b1, 1'b0, 16'h3C96);
        chk(ser == 1'b0, "R8 reload msb", ser, 0);
        for (int k = 1; k <= 33; k++) begin
            cyc(1'b0, 1'b1, 16'hFFFF);
            chk(ser == expect_bit(16'h3C96, k), "R8 restart sequence", ser, expect_bit(16'h3C96, k));
        end

        // R9: back-to-back frames, load on every 64th strobe
        for (int f = 0; f < 3; f++) begin
            logic [15:0] fw;
            fw = 16'hC35A ^ 16'(f * 16'h1111);
            cyc(1'b1, 1'b1, fw);
            chk(ser == fw[15], "R9 frame start", ser, fw[15]);
            for (int k = 1; k < 64; k++) begin
                cyc(1'b0, 1'b0, ~fw);
                cyc(1'b0, 1'b1, ~fw);
                chk(ser == expect_bit(fw, k), "R9 frame bit", ser, expect_bit(fw, k));
            end
        end

        // R1: reset during transmission
        cyc(1'b1, 1'b0, 16'hFFFF);
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 16'hFFFF);
        rst = 1'b1;
        cyc(1'b0, 1'b0, 16'hFFFF);
        rst = 1'b0;
        chk(ser == 1'b0, "R1 reset mid-word", ser, 0);
        for (int k = 0; k < 5; k++) begin
            cyc(1'b0, 1'b1, 16'hFFFF);
            chk(ser == 1'b0, "R1 quiet after reset", ser, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule